// File: doc/BRIEF.md
# Memory Block Copier with Zero Masking

This block moves a run of 32-bit words from one place in memory to another. Software-side logic loads a source byte address, a destination byte address, a word count and a mask-enable flag, then pulses `start`. The engine fetches source words through a word-wide read port and stores them through a word-wide write port. Both ports are request/acknowledge ports with a single beat per handshake. Only memory is addressed. The two low address bits are forced to zero, so every access is word aligned. Any misalignment in the given addresses is discarded.

Reads run ahead of writes through a small internal FIFO. A write stall therefore holds off further reads once the FIFO is full, and the FIFO never overflows. In mask mode each byte lane of a fetched word that is zero has its write strobe cleared. A word that is zero in every lane produces no write request at all. The destination keeps its old contents under transparent source pixels, which makes the copy an overlay blit.

Control is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_COPY` is the state while the transfer runs. Busy is high here.
- `ST_FINISH` means the transfer is complete. Done is high here.

The transitions are:
- IDLE or FINISH to COPY, on an accepted start with a non-zero length.
- IDLE or FINISH to FINISH, on an accepted start with length zero.
- COPY to FINISH, when the last word leaves the write side, whether it was written or skipped.

A start during COPY is not a transition and is ignored.

Top module: `blk_copier`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_req` are all low.
- R2: A `start` sampled while not busy, with `cfg_len` > 0, makes `busy` high and `done` low in the following cycle. `busy` stays high while any word of the transfer is still to be read or written.
- R3: Exactly `cfg_len` reads are issued, in order, at addresses (source & ~3) + 4k for k = 0 .. len-1. Every read address has bits [1:0] equal to 0.
- R4: With mask disabled, word k is written to (destination & ~3) + 4k with the data read from source word k. Writes are issued in order and `wr_strb` = 4'b1111.
- R5: With mask enabled, `wr_strb` bit i is 1 exactly when byte i (data bits 8i+7 .. 8i) of the source word is non-zero. Destination bytes whose strobe is 0 keep their previous value.
- R6: With mask enabled, a source word equal to zero produces no write request, and the destination word is left unchanged. No write request ever carries an all-zero strobe.
- R7: A start with `cfg_len` = 0 sets `done` high in the next cycle, with `busy` low and no read or write request.
- R8: A `start` pulse while `busy` is high is ignored. The running transfer keeps its original parameters and no second transfer follows.
- R9: When the last word is handled, `busy` falls and `done` rises together. `done` stays high until the next accepted start. `busy` and `done` are never high together.
- R10: At most DEPTH (default 4) words are read ahead of the write side. If writes stall, reads stop after DEPTH words have been read ahead.
- R11: A request held without acknowledge stays asserted in the next cycle with the same address, and for writes with the same data and strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only when not busy |
| cfg_src | input | AW | Source byte address |
| cfg_dst | input | AW | Destination byte address |
| cfg_len | input | LW | Transfer length in 32-bit words |
| cfg_mask | input | 1 | Enable zero-byte masking |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer complete |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read word address (byte units) |
| rd_ack | input | 1 | Read acknowledge, data valid with it |
| rd_data | input | DW | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write word address (byte units) |
| wr_data | output | DW | Write data |
| wr_strb | output | DW/8 | Per-byte write enables |
| wr_ack | input | 1 | Write acknowledge |

## Verification
The hardest case to reach from the ports is a full read-ahead FIFO: reads must stop at exactly DEPTH words while writes are blocked, and must then resume without losing or repeating a word. The stimulus reaches it by withholding every write acknowledge for a long window at the start of an unmasked copy, while reads are granted freely. The bench counts the read handshakes at the end of that window and then lets the copy drain. Mask-mode runs use a source pattern that mixes all-zero words, words with only some zero lanes, and words with none. Acknowledges on both ports follow a pseudo-random pattern, so that skipped beats meet both stalled and immediate writes.

// File: rtl/bc_pkg.sv
package bc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COPY   = 2'd1,
        ST_FINISH = 2'd2
    } bc_state_e;
endpackage

// File: rtl/bc_fifo.sv
module bc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                store[wp] <= din;
                wp        <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    assign dout  = store[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign count = cnt;
endmodule

// File: rtl/bc_lane_mask.sv
module bc_lane_mask #(
    parameter int DW    = 32,
    localparam int LANES = DW / 8
) (
    input  logic [DW-1:0]    data,
    input  logic             mask_en,
    output logic [LANES-1:0] strb,
    output logic             skip
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strb[g] = !mask_en || (data[g*8 +: 8] != 8'h00);
    end
    assign skip = mask_en && (strb == '0);
endmodule

// File: rtl/bc_addr_gen.sv
module bc_addr_gen #(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          none,
    output logic          last
);
    localparam logic [AW-1:0] ALIGN = ~AW'(BYTES - 1);
    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            left_q <= '0;
        end else if (load) begin
            addr   <= base & ALIGN;
            left_q <= len;
        end else if (adv) begin
            addr   <= addr + AW'(BYTES);
            left_q <= left_q - 1'b1;
        end
    end

    assign none = (left_q == '0);
    assign last = (left_q == LW'(1));
endmodule

// File: rtl/blk_copier.sv
module blk_copier
    import bc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LW    = 16,
    parameter int DEPTH = 4,
    localparam int SW   = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_mask,
    output logic          busy,
    output logic          done,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [SW-1:0] wr_strb,
    input  logic          wr_ack
);
    bc_state_e state_q, state_d;
    logic      mask_q;
    logic      accept, rd_fire, wr_step, head_valid, lane_skip;
    logic      rd_none, rd_last, wr_none, wr_last;
    logic      fifo_full, fifo_empty;
    logic [DW-1:0] head;
    logic [CW-1:0] fifo_cnt;

    assign accept = start && (state_q != ST_COPY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) mask_q <= cfg_mask;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (accept) state_d = (cfg_len == '0) ? ST_FINISH : ST_COPY;
            end
            ST_COPY: begin
                if (wr_step && wr_last) state_d = ST_FINISH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        rd_req     = 1'b0;
        head_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COPY: begin
                busy       = 1'b1;
                rd_req     = !rd_none && !fifo_full;
                head_valid = !fifo_empty;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign rd_fire = rd_req && rd_ack;
    assign wr_req  = head_valid && !lane_skip;
    assign wr_step = head_valid && (lane_skip || wr_ack);
    assign wr_data = head;

    bc_addr_gen #(.AW(AW), .LW(LW), .BYTES(SW)) u_rd_gen (
        .clk(clk), .rst_n(rst_n), .load(accept), .base(cfg_src), .len(cfg_len),
        .adv(rd_fire), .addr(rd_addr), .none(rd_none), .last(rd_last)
    );

    bc_addr_gen #(.AW(AW), .LW(LW), .BYTES(SW)) u_wr_gen (
        .clk(clk), .rst_n(rst_n), .load(accept), .base(cfg_dst), .len(cfg_len),
        .adv(wr_step), .addr(wr_addr), .none(wr_none), .last(wr_last)
    );

    bc_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rd_fire), .din(rd_data), .pop(wr_step),
        .dout(head), .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
    );

    bc_lane_mask #(.DW(DW)) u_mask (
        .data(head), .mask_en(mask_q), .strb(wr_strb), .skip(lane_skip)
    );

    logic unused_ok;
    assign unused_ok = rd_last ^ wr_none;
endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [DW/8-1:0] wr_strb,
    input logic [CW-1:0] fifo_cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R11
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)); // R11
    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_addr[1:0] == 2'b00); // R3
    AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_strb != '0); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !wr_req); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R9
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !(wr_req && wr_ack) |=> busy); // R8
endmodule

bind blk_copier bc_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .fifo_cnt(fifo_cnt)
);

// File: tb/blk_copier_test.sv
module blk_copier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_len = '0;
    logic        cfg_mask = 1'b0;
    logic        busy, done, rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, wr_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic [3:0]  wr_strb;

    always #2 clk = ~clk;

    blk_copier uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_len(cfg_len), .cfg_mask(cfg_mask), .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_ack(wr_ack)
    );

    typedef struct packed { logic [31:0] a; logic [31:0] d; logic [3:0] s; } wr_t;

    int          errors = 0, checks = 0;
    bit          finished = 0;
    logic [31:0] mem [256];
    logic [31:0] img [256];
    logic [31:0] exp_rd [$];
    wr_t         exp_wr [$];
    logic [15:0] lfsr = 16'hACE1;
    int          wr_hold = 0;
    int          rd_count = 0;
    bit          rd_pend = 0, wr_pend = 0;
    logic [31:0] rd_pend_a;
    wr_t         wr_pend_v;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes(input logic [31:0] d, input bit m);
        logic [3:0] s;
        for (int b = 0; b < 4; b++) s[b] = !m || (d[b*8 +: 8] != 8'h00);
        return s;
    endfunction

    task automatic tick();
        wr_t w;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if ((exp_rd.size() != 0 || exp_wr.size() != 0))
            check(busy == 1'b1, "R2 busy while pending", {63'd0, busy}, 64'd1);
        if (rd_pend)
            check(rd_req && rd_addr == rd_pend_a, "R11 read hold", rd_addr, rd_pend_a);
        if (wr_pend)
            check(wr_req && wr_addr == wr_pend_v.a && wr_data == wr_pend_v.d && wr_strb == wr_pend_v.s,
                  "R11 write hold", {wr_addr, wr_data}, {wr_pend_v.a, wr_pend_v.d});
        // read port
        rd_ack  = 1'b0;
        rd_pend = 1'b0;
        if (rd_req) begin
            if (lfsr[0] || lfsr[3]) begin
                rd_ack  = 1'b1;
                rd_data = mem[rd_addr[9:2]];
                rd_count++;
                if (exp_rd.size() == 0)
                    check(1'b0, "R3 extra read", rd_addr, 64'd0);
                else
                    check(rd_addr == exp_rd.pop_front(), "R3 read address", rd_addr, rd_addr ^ 1);
            end else begin
                rd_pend   = 1'b1;
                rd_pend_a = rd_addr;
            end
        end
        // write port
        wr_ack  = 1'b0;
        wr_pend = 1'b0;
        if (wr_hold > 0) wr_hold--;
        if (wr_req) begin
            if (wr_hold == 0 && (lfsr[1] || lfsr[5])) begin
                wr_ack = 1'b1;
                if (exp_wr.size() == 0)
                    check(1'b0, "R6 unexpected write", wr_addr, 64'd0);
                else begin
                    w = exp_wr.pop_front();
                    check(wr_addr == w.a, "R4 write address", wr_addr, w.a);
                    check(wr_data == w.d && wr_strb == w.s, "R5 write data/strobe",
                          {wr_data, 28'd0, wr_strb}, {w.d, 28'd0, w.s});
                end
                for (int b = 0; b < 4; b++)
                    if (wr_strb[b]) mem[wr_addr[9:2]][b*8 +: 8] = wr_data[b*8 +: 8];
            end else begin
                wr_pend   = 1'b1;
                wr_pend_v = '{a: wr_addr, d: wr_data, s: wr_strb};
            end
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 128; i++) begin
            unique case (i % 4)
                0: mem[i] = 32'h0;
                1: mem[i] = 32'h1100_0022 + 32'(i);
                2: mem[i] = 32'h0000_3300 | (32'(i) << 16);
                default: mem[i] = 32'h4455_6677 ^ (32'(i) << 8);
            endcase
        end
        for (int i = 128; i < 256; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
    endtask

    task automatic run_copy(input int sw, input int dw, input int len, input bit m,
                            input int stall, input bit poke);
        logic [3:0] s;
        logic [31:0] d;
        bit was_done;
        int t;
        fill_mem();
        for (int i = 0; i < 256; i++) img[i] = mem[i];
        for (int k = 0; k < len; k++) begin
            d = mem[sw + k];
            s = lanes(d, m);
            exp_rd.push_back(32'((sw + k) * 4));
            if (s != 4'h0) exp_wr.push_back('{a: 32'((dw + k) * 4), d: d, s: s});
            for (int b = 0; b < 4; b++) if (s[b]) img[dw + k][b*8 +: 8] = d[b*8 +: 8];
        end
        was_done = done;
        cfg_src  = 32'(sw * 4) | 32'h3;   // low bits must be ignored (R3)
        cfg_dst  = 32'(dw * 4) | 32'h1;
        cfg_len  = 16'(len);
        cfg_mask = m;
        start    = 1'b1;
        wr_hold  = stall;
        rd_count = 0;
        tick();
        start = 1'b0;
        tick();
        check(busy == 1'b1 && done == 1'b0, "R2 start accepted", {busy, done}, 2'b10);
        if (was_done) check(done == 1'b0, "R9 done cleared by start", done, 0);
        t = 0;
        while (!done && t < 3000) begin
            if (poke && t == 4) begin
                start = 1'b1; cfg_src = 32'h100; cfg_len = 16'd3; cfg_mask = ~m;
            end
            if (poke && t == 5) start = 1'b0;
            if (stall > 0 && t == stall - 3)
                check(rd_count == 4, "R10 read-ahead limit", rd_count, 4);
            tick();
            t++;
        end
        check(done == 1'b1 && busy == 1'b0, "R9 completion", {busy, done}, 2'b01);
        check(exp_rd.size() == 0, "R3 read count", exp_rd.size(), 0);
        check(exp_wr.size() == 0, "R4 write count", exp_wr.size(), 0);
        exp_rd.delete();
        exp_wr.delete();
        for (int k = 0; k <= len; k++)
            check(mem[dw + k] == img[dw + k], m ? "R6 masked image" : "R4 copy image",
                  mem[dw + k], img[dw + k]);
        for (int i = 0; i < 12; i++) begin
            tick();
            check(done && !busy && !rd_req && !wr_req, poke ? "R8 no second run" : "R9 done held",
                  {done, busy, rd_req, wr_req}, 4'b1000);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check(!busy && !done && !rd_req && !wr_req, "R1 reset state", {busy, done, rd_req, wr_req}, 0);
        run_copy(0, 160, 12, 1'b0, 0, 1'b0);   // R4 plain copy
        run_copy(3, 140, 16, 1'b1, 0, 1'b0);   // R5, R6 masked overlay
        run_copy(8, 200, 10, 1'b0, 40, 1'b0);  // R10 write stall
        run_copy(20, 170, 8, 1'b0, 0, 1'b1);   // R8 start while busy
        // R7 zero length
        cfg_len = 16'd0;
        start   = 1'b1;
        tick();
        start = 1'b0;
        tick();
        check(done && !busy && !rd_req && !wr_req, "R7 zero length", {done, busy, rd_req, wr_req}, 4'b1000);
        for (int i = 0; i < 8; i++) begin
            tick();
            check(!rd_req && !wr_req && !busy, "R7 no requests", {rd_req, wr_req, busy}, 0);
        end
        run_copy(40, 230, 9, 1'b1, 0, 1'b0);   // R5 again after zero-length run
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule